// File: doc/BRIEF.md
# Bus Turnaround Gap Inserter

This block sits in front of the transaction sequencer of an external static memory controller. It decides how many idle controller clock cycles must pass between the end of one transaction and the start of the next. It then holds the next transaction off until those cycles have gone by. When a transaction completes, the block stores a short record of it: whether it was synchronous, whether it was a write, its bank number, and whether that bank runs in address/data multiplexed mode or in the alternate asynchronous mode D.

The sequencer presents the attributes of the transaction it wants to start next. The block compares them with the stored record and selects one of four gap kinds: none, the programmed turnaround (field value plus one), a fixed short gap of 2, or a fixed long gap of 3. A counter of cycles elapsed since the last completion is compared with that gap, and `gap_clear` goes high once enough cycles have passed. The comparison is made against whatever is pending now, so a change of the pending transaction takes effect at once.

Top module: `tgap_inserter`

## Requirements
- R1: After reset no previous transaction is recorded, and `gap_clear` is high for any pending transaction.
- R2: When the last completed transaction was a read (`done_write`=0), the gap is 0 whatever is pending.
- R3: After an asynchronous write (`done_sync`=0, `done_write`=1), a pending read (`nxt_write`=0) of any bank, synchronous or not, gets a gap of `cfg_turn`+1 cycles.
- R4: After an asynchronous write, a pending write to a different bank gets a gap of `cfg_turn`+1 cycles.
- R5: After an asynchronous write with `done_muxed`=0 and `done_moded`=0, a pending write to the same bank gets a gap of 0.
- R6: After an asynchronous write with `done_muxed`=1 or `done_moded`=1, a pending write to the same bank gets a gap of `cfg_turn`+1 cycles.
- R7: After a synchronous write (`done_sync`=1, `done_write`=1), a gap of exactly 2 applies to a pending synchronous write to the same bank and to any pending asynchronous read or write.
- R8: After a synchronous write, a gap of exactly 3 applies to a pending synchronous write to a different bank and to a pending synchronous read of any bank.
- R9: A gap of G cycles means that `gap_clear` is low for exactly the G clock cycles that follow the cycle in which `done_pulse` is high. It then stays high until the next completion, and a new completion restarts the count.
- R10: The gap is evaluated against the pending attributes presented in the current cycle, so changing them during a gap immediately raises or lowers `gap_clear` according to the cycles already elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_turn | input | 4 | Programmed turnaround field; the gap is this value plus one |
| done_pulse | input | 1 | High for one cycle when a transaction completes |
| done_sync | input | 1 | Completed transaction was synchronous |
| done_write | input | 1 | Completed transaction was a write |
| done_bank | input | 2 | Bank of the completed transaction |
| done_muxed | input | 1 | Completed transaction's bank uses multiplexed address/data |
| done_moded | input | 1 | Completed transaction's bank uses asynchronous mode D |
| nxt_sync | input | 1 | Pending transaction is synchronous |
| nxt_write | input | 1 | Pending transaction is a write |
| nxt_bank | input | 2 | Bank of the pending transaction |
| gap_clear | output | 1 | High when the pending transaction may start |

## Verification
The bench pairs each kind of completed transaction (asynchronous read, synchronous read, asynchronous write with and without the multiplexed or mode-D flags, synchronous write) with pending transactions that vary direction, synchronism and same or different bank. It measures how many cycles `gap_clear` stays low, which tells the programmed, short, long and zero gaps apart. Programmed values of 0, 3, 5 and 15 separate an off-by-one in the field from a saturation fault. Further runs restart a gap with a second completion, hold past the gap to confirm that the output stays high, and switch the pending attributes mid-gap to show that the decision follows the present request and not a value latched earlier.

// File: rtl/tgap_pkg.sv
// Package: shared gap-kind encoding for the turnaround gap inserter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tgap_pkg;

    // Which rule chose the gap between the previous and the pending transaction
    typedef enum logic [1:0] {
        GAP_NONE  = 2'd0,
        GAP_PROG  = 2'd1,
        GAP_SHORT = 2'd2,
        GAP_LONG  = 2'd3
    } gap_kind_e;

endpackage

// File: rtl/tgap_record.sv
// Module: tgap_record
// Stores the attributes of the most recently completed transaction.
// Assumes: done_pulse is a single-cycle strobe with attributes valid alongside it.
module tgap_record #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_pulse,
    input  logic              done_sync,
    input  logic              done_write,
    input  logic [BANK_W-1:0] done_bank,
    input  logic              done_muxed,
    input  logic              done_moded,
    output logic              prev_valid,
    output logic              prev_sync,
    output logic              prev_write,
    output logic [BANK_W-1:0] prev_bank,
    output logic              prev_muxed,
    output logic              prev_moded
);

    // Capture the completed transaction; clear the record on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_sync  <= 1'b0;
            prev_write <= 1'b0;
            prev_bank  <= '0;
            prev_muxed <= 1'b0;
            prev_moded <= 1'b0;
        end else if (done_pulse) begin
            prev_valid <= 1'b1;
            prev_sync  <= done_sync;
            prev_write <= done_write;
            prev_bank  <= done_bank;
            prev_muxed <= done_muxed;
            prev_moded <= done_moded;
        end
    end

endmodule

// File: rtl/tgap_rules.sv
// Module: tgap_rules
// Combinational rule table: picks the gap kind and length from the previous
// record and the pending transaction.
// Assumes: CNT_W can hold 2**TURN_W and the fixed gaps.
module tgap_rules
    import tgap_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int TURN_W    = 4,
    parameter int SHORT_GAP = 2,
    parameter int LONG_GAP  = 3,
    parameter int CNT_W     = 5
) (
    input  logic              prev_valid,
    input  logic              prev_sync,
    input  logic              prev_write,
    input  logic [BANK_W-1:0] prev_bank,
    input  logic              prev_muxed,
    input  logic              prev_moded,
    input  logic              nxt_sync,
    input  logic              nxt_write,
    input  logic [BANK_W-1:0] nxt_bank,
    input  logic [TURN_W-1:0] cfg_turn,
    output gap_kind_e         gap_kind,
    output logic [CNT_W-1:0]  gap_need
);

    logic same_bank;
    logic wide_bank;

    assign same_bank = (prev_bank == nxt_bank);
    assign wide_bank = prev_muxed | prev_moded;

    // Classify the previous/pending pair into one of the gap kinds
    always_comb begin
        gap_kind = GAP_NONE;
        if (prev_valid && prev_write) begin
            if (!prev_sync) begin
                if (!nxt_write || !same_bank || wide_bank) begin
                    gap_kind = GAP_PROG;
                end
            end else begin
                if (!nxt_sync || (nxt_write && same_bank)) begin
                    gap_kind = GAP_SHORT;
                end else begin
                    gap_kind = GAP_LONG;
                end
            end
        end
    end

    // Turn the gap kind into a cycle count
    always_comb begin
        unique case (gap_kind)
            GAP_PROG:  gap_need = CNT_W'(cfg_turn) + CNT_W'(1);
            GAP_SHORT: gap_need = CNT_W'(SHORT_GAP);
            GAP_LONG:  gap_need = CNT_W'(LONG_GAP);
            default:   gap_need = '0;
        endcase
    end

endmodule

// File: rtl/tgap_timer.sv
// Module: tgap_timer
// Counts cycles since the last completion, saturating at MAX_GAP, and
// compares the count with the required gap.
// Assumes: gap_need never exceeds MAX_GAP.
module tgap_timer #(
    parameter int MAX_GAP = 16,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_pulse,
    input  logic [CNT_W-1:0] gap_need,
    output logic [CNT_W-1:0] elapsed,
    output logic             gap_clear
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_GAP);

    // Restart on completion, otherwise count up to the saturation value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= SAT;
        end else if (done_pulse) begin
            elapsed <= '0;
        end else if (elapsed < SAT) begin
            elapsed <= elapsed + CNT_W'(1);
        end
    end

    assign gap_clear = (elapsed >= gap_need);

endmodule

// File: rtl/tgap_inserter.sv
// Module: tgap_inserter (top)
// Holds off the next static memory transaction for the turnaround gap that
// the previous/pending pair requires.
// Assumes: the sequencer starts a transaction only while gap_clear is high.
module tgap_inserter
    import tgap_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int TURN_W    = 4,
    parameter int SHORT_GAP = 2,
    parameter int LONG_GAP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TURN_W-1:0] cfg_turn,
    input  logic              done_pulse,
    input  logic              done_sync,
    input  logic              done_write,
    input  logic [BANK_W-1:0] done_bank,
    input  logic              done_muxed,
    input  logic              done_moded,
    input  logic              nxt_sync,
    input  logic              nxt_write,
    input  logic [BANK_W-1:0] nxt_bank,
    output logic              gap_clear
);

    localparam int MAX_GAP = 2 ** TURN_W;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    logic              prev_valid;
    logic              prev_sync;
    logic              prev_write;
    logic [BANK_W-1:0] prev_bank;
    logic              prev_muxed;
    logic              prev_moded;
    gap_kind_e         gap_kind;
    logic [CNT_W-1:0]  gap_need;
    logic [CNT_W-1:0]  elapsed;

    tgap_record #(.BANK_W(BANK_W)) u_record (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_pulse (done_pulse),
        .done_sync  (done_sync),
        .done_write (done_write),
        .done_bank  (done_bank),
        .done_muxed (done_muxed),
        .done_moded (done_moded),
        .prev_valid (prev_valid),
        .prev_sync  (prev_sync),
        .prev_write (prev_write),
        .prev_bank  (prev_bank),
        .prev_muxed (prev_muxed),
        .prev_moded (prev_moded)
    );

    tgap_rules #(
        .BANK_W    (BANK_W),
        .TURN_W    (TURN_W),
        .SHORT_GAP (SHORT_GAP),
        .LONG_GAP  (LONG_GAP),
        .CNT_W     (CNT_W)
    ) u_rules (
        .prev_valid (prev_valid),
        .prev_sync  (prev_sync),
        .prev_write (prev_write),
        .prev_bank  (prev_bank),
        .prev_muxed (prev_muxed),
        .prev_moded (prev_moded),
        .nxt_sync   (nxt_sync),
        .nxt_write  (nxt_write),
        .nxt_bank   (nxt_bank),
        .cfg_turn   (cfg_turn),
        .gap_kind   (gap_kind),
        .gap_need   (gap_need)
    );

    tgap_timer #(
        .MAX_GAP (MAX_GAP),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_pulse (done_pulse),
        .gap_need   (gap_need),
        .elapsed    (elapsed),
        .gap_clear  (gap_clear)
    );

endmodule

// File: rtl/tgap_inserter_chk.sv
// Module: tgap_inserter_chk
// Property checker bound into tgap_inserter; observes the record, the rule
// output and the timer.
// Assumes: CNT_W matches the top's derived counter width.
module tgap_inserter_chk #(
    parameter int BANK_W = 2,
    parameter int TURN_W = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TURN_W-1:0] cfg_turn,
    input logic              done_pulse,
    input logic              prev_valid,
    input logic              prev_sync,
    input logic              prev_write,
    input logic [BANK_W-1:0] prev_bank,
    input logic              prev_muxed,
    input logic              prev_moded,
    input logic              nxt_sync,
    input logic              nxt_write,
    input logic [BANK_W-1:0] nxt_bank,
    input logic [CNT_W-1:0]  gap_need,
    input logic [CNT_W-1:0]  elapsed,
    input logic              gap_clear
);

    // R1
    no_record_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_valid |-> gap_clear);

    // R2
    read_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && !prev_write) |-> gap_clear);

    // R3
    async_wr_read_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && prev_write && !prev_sync && !nxt_write)
        |-> gap_need == CNT_W'(cfg_turn) + CNT_W'(1));

    // R5
    async_wr_same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && prev_write && !prev_sync && nxt_write &&
         prev_bank == nxt_bank && !prev_muxed && !prev_moded) |-> gap_clear);

    // R7
    sync_wr_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && prev_write && prev_sync && !nxt_sync) |-> gap_need == CNT_W'(2));

    // R8
    sync_wr_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && prev_write && prev_sync && nxt_sync && !nxt_write)
        |-> gap_need == CNT_W'(3));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> elapsed == '0);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_pulse && elapsed < CNT_W'(2 ** TURN_W)) |=> elapsed == $past(elapsed) + CNT_W'(1));

    // R9
    no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed <= CNT_W'(2 ** TURN_W));

endmodule

bind tgap_inserter tgap_inserter_chk #(
    .BANK_W (BANK_W),
    .TURN_W (TURN_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_turn   (cfg_turn),
    .done_pulse (done_pulse),
    .prev_valid (prev_valid),
    .prev_sync  (prev_sync),
    .prev_write (prev_write),
    .prev_bank  (prev_bank),
    .prev_muxed (prev_muxed),
    .prev_moded (prev_moded),
    .nxt_sync   (nxt_sync),
    .nxt_write  (nxt_write),
    .nxt_bank   (nxt_bank),
    .gap_need   (gap_need),
    .elapsed    (elapsed),
    .gap_clear  (gap_clear)
);

// File: tb/tgap_inserter_tb.sv
`timescale 1ns/1ps
// Directed bench for tgap_inserter: one task per scenario.
module tgap_inserter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_turn = '0;
    logic       done_pulse = 1'b0;
    logic       done_sync = 1'b0;
    logic       done_write = 1'b0;
    logic [1:0] done_bank = '0;
    logic       done_muxed = 1'b0;
    logic       done_moded = 1'b0;
    logic       nxt_sync = 1'b0;
    logic       nxt_write = 1'b0;
    logic [1:0] nxt_bank = '0;
    logic       gap_clear;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tgap_inserter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_turn   (cfg_turn),
        .done_pulse (done_pulse),
        .done_sync  (done_sync),
        .done_write (done_write),
        .done_bank  (done_bank),
        .done_muxed (done_muxed),
        .done_moded (done_moded),
        .nxt_sync   (nxt_sync),
        .nxt_write  (nxt_write),
        .nxt_bank   (nxt_bank),
        .gap_clear  (gap_clear)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_nxt(input bit s, input bit w, input int b);
        nxt_sync  = s;
        nxt_write = w;
        nxt_bank  = 2'(b);
    endtask

    // Pulse one completion; returns at the falling edge after the capturing edge
    task automatic complete(input bit s, input bit w, input int b, input bit mx, input bit md);
        @(negedge clk);
        done_sync  = s;
        done_write = w;
        done_bank  = 2'(b);
        done_muxed = mx;
        done_moded = md;
        done_pulse = 1'b1;
        @(negedge clk);
        done_pulse = 1'b0;
    endtask

    // Count cycles with gap_clear low, starting right after a completion
    task automatic measure(output int n);
        n = 0;
        #1;
        while (!gap_clear && n < 40) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    task automatic run_gap(input string req, input bit ps, input bit pw, input int pb,
                           input bit mx, input bit md, input bit ns, input bit nw,
                           input int nb, input int exp);
        int n;
        set_nxt(ns, nw, nb);
        complete(ps, pw, pb, mx, md);
        measure(n);
        chk(req, n, exp);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        set_nxt(1'b0, 1'b1, 0); #1; chk("R1 async write pending", gap_clear, 1);
        set_nxt(1'b1, 1'b0, 3); #1; chk("R1 sync read pending", gap_clear, 1);
        set_nxt(1'b1, 1'b1, 1); #1; chk("R1 sync write pending", gap_clear, 1);
    endtask

    task automatic t_after_read();
        cfg_turn = 4'd9;
        run_gap("R2 async read then sync write", 0, 0, 1, 1, 1, 1, 1, 2, 0);
        run_gap("R2 sync read then async read", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_async_wr_read();
        cfg_turn = 4'd5;
        run_gap("R3 async wr then read same bank", 0, 1, 2, 0, 0, 0, 0, 2, 6);
        cfg_turn = 4'd0;
        run_gap("R3 async wr then sync read other bank", 0, 1, 2, 0, 0, 1, 0, 1, 1);
        cfg_turn = 4'd15;
        run_gap("R3 async wr then read max field", 0, 1, 0, 0, 0, 0, 0, 3, 16);
    endtask

    task automatic t_async_wr_wr();
        cfg_turn = 4'd3;
        run_gap("R4 async wr then write other bank", 0, 1, 0, 0, 0, 0, 1, 1, 4);
        run_gap("R4 async wr then sync write other bank", 0, 1, 3, 0, 0, 1, 1, 0, 4);
        run_gap("R5 async wr then write same bank", 0, 1, 1, 0, 0, 0, 1, 1, 0);
        run_gap("R6 muxed async wr then write same bank", 0, 1, 1, 1, 0, 0, 1, 1, 4);
        run_gap("R6 mode D async wr then write same bank", 0, 1, 2, 0, 1, 0, 1, 2, 4);
    endtask

    task automatic t_sync_wr();
        cfg_turn = 4'd12;
        run_gap("R7 sync wr then sync write same bank", 1, 1, 1, 0, 0, 1, 1, 1, 2);
        run_gap("R7 sync wr then async read", 1, 1, 1, 0, 0, 0, 0, 1, 2);
        run_gap("R7 sync wr then async write other bank", 1, 1, 0, 0, 0, 0, 1, 3, 2);
        run_gap("R8 sync wr then sync write other bank", 1, 1, 0, 0, 0, 1, 1, 2, 3);
        run_gap("R8 sync wr then sync read same bank", 1, 1, 3, 0, 0, 1, 0, 3, 3);
        run_gap("R8 sync wr then sync read other bank", 1, 1, 3, 0, 0, 1, 0, 0, 3);
    endtask

    task automatic t_restart();
        int n;
        cfg_turn = 4'd9;
        set_nxt(1'b0, 1'b0, 0);
        complete(1'b0, 1'b1, 0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        #1; chk("R9 low mid gap", gap_clear, 0);
        complete(1'b0, 1'b1, 0, 1'b0, 1'b0);
        measure(n);
        chk("R9 restart full gap", n, 10);
        repeat (25) @(negedge clk);
        #1; chk("R9 stays high after gap", gap_clear, 1);
    endtask

    task automatic t_pending_change();
        cfg_turn = 4'd7;
        set_nxt(1'b0, 1'b0, 0);
        complete(1'b0, 1'b1, 0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        #1; chk("R10 read pending low", gap_clear, 0);
        set_nxt(1'b0, 1'b1, 0);
        #1; chk("R10 switch to same bank write high", gap_clear, 1);
        set_nxt(1'b0, 1'b0, 0);
        #1; chk("R10 switch back to read low", gap_clear, 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_after_read();
        t_async_wr_read();
        t_async_wr_wr();
        t_sync_wr();
        t_restart();
        t_pending_change();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule